// File: doc/BRIEF.md
# Single-Cycle Core Instruction Decoder

This block is the purely combinational control decoder of a single-cycle 32-bit load/store core. It reads the 6-bit opcode from instruction bits 31:26. It also reads a zero flag, which is high when the data on the first register read port equals zero. From these two inputs it produces every steering select and enable that the datapath needs in the same cycle.

The block covers these instructions:

- Add, subtract, multiply and compare-equal, each in a register form and a constant form.
- Load, store and PC-relative load.
- Register-indirect jump.
- Branch-if-zero and branch-if-nonzero.

Any other opcode is illegal. It diverts the program counter to the trap vector and saves the return address in register R30.

The decoder has no clock and no state. It has no data stream either, so it has no valid/ready handshake. Every pin is a plain level that follows its inputs within the same cycle. The core must present a stable opcode and zero flag before its clock edge, and it consumes the outputs at that edge.

Top module: `ctl_decode_unit`

## Requirements
- R1: For branch-if-zero (opcode 0x1C), pc_sel is 1 when z is 1 and 0 when z is 0. For branch-if-nonzero (opcode 0x1D) the condition is inverted.
- R2: The jump opcode 0x1B gives pc_sel 2. Every legal opcode that is not a jump or branch gives pc_sel 0.
- R3: The legal opcodes are 0x18, 0x19, 0x1B, 0x1C, 0x1D, 0x1F, 0x20, 0x21, 0x22, 0x24, 0x30, 0x31, 0x32 and 0x34. Any other opcode gives pc_sel 3, reg_we 1, wa_sel 1 (write R30) and wd_sel 0. In that case ra2_sel, a_sel, b_sel, alu_fn, mem_we and mem_oe are all 0.
- R4: ra2_sel is 1 only for the store opcode 0x19, so that the second read port fetches the Rc register as write data.
- R5: b_sel is 1 (sign-extended literal) for the constant-form opcodes 0x30, 0x31, 0x32 and 0x34, and for load (0x18) and store (0x19). It is 0 for all other opcodes.
- R6: wd_sel is 0 (PC+4) for jump and both branches. It is 1 (ALU result) for the eight arithmetic opcodes, and 2 (memory read data) for load and for PC-relative load (0x1F). For store it is 0.
- R7: mem_we is 1 only for store. mem_oe is 1 only for load and PC-relative load.
- R8: reg_we is 1 for every opcode except store.
- R9: alu_fn is 0 (add) for opcodes with low bits 0 and for load and store. It is 1 (subtract) for low bits 1, 2 (multiply) for low bits 2, and 3 (compare-equal) for low bits 4. PC-relative load gives alu_fn 4 (pass A) with a_sel 1. Every other opcode gives alu_fn 0 and a_sel 0.
- R10: z has no effect on any output for any opcode other than 0x1C and 0x1D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 6 | Instruction bits 31:26 |
| z | input | 1 | High when register read data 1 equals zero |
| pc_sel | output | 2 | Next-PC source: 0 PC+4, 1 branch target, 2 register, 3 trap vector |
| ra2_sel | output | 1 | Second read port address: 0 Rb, 1 Rc |
| a_sel | output | 1 | ALU A input: 0 register data, 1 PC-relative address |
| b_sel | output | 1 | ALU B input: 0 register data, 1 sign-extended literal |
| wd_sel | output | 2 | Register write data: 0 PC+4, 1 ALU, 2 memory |
| alu_fn | output | 4 | ALU operation code |
| reg_we | output | 1 | Register file write enable |
| mem_we | output | 1 | Data memory write enable |
| mem_oe | output | 1 | Data memory read enable |
| wa_sel | output | 1 | Write address: 0 Rc, 1 R30 |

## Verification
The bench builds the decoder with its default parameters: a 6-bit opcode and a 4-bit ALU function code. With a 6-bit opcode the whole opcode space is small enough to sweep exhaustively under both values of z. That sweep reaches every illegal hole, including the unused codes sitting between the legal arithmetic codes. Random opcode and flag pairs are then checked against a bench model. Finally, the zero flag is toggled under each non-branch opcode to show that it has no effect there.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  typedef enum logic [2:0] {
    K_ILL, K_ALU, K_LD, K_ST, K_LDR, K_JMP, K_BEQ, K_BNE
  } kind_t;

  localparam int OPC_LD   = 'h18;
  localparam int OPC_ST   = 'h19;
  localparam int OPC_JMP  = 'h1B;
  localparam int OPC_BEQ  = 'h1C;
  localparam int OPC_BNE  = 'h1D;
  localparam int OPC_LDR  = 'h1F;
  localparam int OPC_ADD  = 'h20;
  localparam int OPC_SUB  = 'h21;
  localparam int OPC_MUL  = 'h22;
  localparam int OPC_CEQ  = 'h24;
  localparam int OPC_KOFS = 'h10;

  localparam int FN_ADD   = 0;
  localparam int FN_SUB   = 1;
  localparam int FN_MUL   = 2;
  localparam int FN_CEQ   = 3;
  localparam int FN_PASSA = 4;

  localparam int PCS_SEQ  = 0;
  localparam int PCS_BR   = 1;
  localparam int PCS_JT   = 2;
  localparam int PCS_TRAP = 3;

  localparam int WDS_PC   = 0;
  localparam int WDS_ALU  = 1;
  localparam int WDS_MEM  = 2;
endpackage

// File: rtl/ctl_op_classify.sv
module ctl_op_classify
  import ctl_pkg::*;
#(
  parameter int OP_W = 6,
  parameter int FN_W = 4
) (
  input  logic [OP_W-1:0] op,
  output kind_t           kind,
  output logic            is_const,
  output logic [FN_W-1:0] fn
);
  always_comb begin
    kind     = K_ILL;
    is_const = 1'b0;
    fn       = '0;
    case (op)
      OP_W'(OPC_LD):  kind = K_LD;
      OP_W'(OPC_ST):  kind = K_ST;
      OP_W'(OPC_JMP): kind = K_JMP;
      OP_W'(OPC_BEQ): kind = K_BEQ;
      OP_W'(OPC_BNE): kind = K_BNE;
      OP_W'(OPC_LDR): kind = K_LDR;
      OP_W'(OPC_ADD), OP_W'(OPC_ADD + OPC_KOFS): begin
        kind = K_ALU; fn = FN_W'(FN_ADD);
      end
      OP_W'(OPC_SUB), OP_W'(OPC_SUB + OPC_KOFS): begin
        kind = K_ALU; fn = FN_W'(FN_SUB);
      end
      OP_W'(OPC_MUL), OP_W'(OPC_MUL + OPC_KOFS): begin
        kind = K_ALU; fn = FN_W'(FN_MUL);
      end
      OP_W'(OPC_CEQ), OP_W'(OPC_CEQ + OPC_KOFS): begin
        kind = K_ALU; fn = FN_W'(FN_CEQ);
      end
      default: kind = K_ILL;
    endcase
    if (kind == K_ALU) is_const = op[4];
  end
endmodule

// File: rtl/ctl_pc_steer.sv
module ctl_pc_steer
  import ctl_pkg::*;
(
  input  kind_t      kind,
  input  logic       z,
  output logic [1:0] pc_sel
);
  always_comb begin
    case (kind)
      K_BEQ:   pc_sel = z ? 2'(PCS_BR) : 2'(PCS_SEQ);
      K_BNE:   pc_sel = z ? 2'(PCS_SEQ) : 2'(PCS_BR);
      K_JMP:   pc_sel = 2'(PCS_JT);
      K_ILL:   pc_sel = 2'(PCS_TRAP);
      default: pc_sel = 2'(PCS_SEQ);
    endcase
  end
endmodule

// File: rtl/ctl_sel_gen.sv
module ctl_sel_gen
  import ctl_pkg::*;
#(
  parameter int FN_W = 4
) (
  input  kind_t           kind,
  input  logic            is_const,
  input  logic [FN_W-1:0] fn_in,
  output logic            ra2_sel,
  output logic            a_sel,
  output logic            b_sel,
  output logic [1:0]      wd_sel,
  output logic [FN_W-1:0] alu_fn,
  output logic            reg_we,
  output logic            mem_we,
  output logic            mem_oe,
  output logic            wa_sel
);
  always_comb begin
    ra2_sel = 1'b0;
    a_sel   = 1'b0;
    b_sel   = 1'b0;
    wd_sel  = 2'(WDS_PC);
    alu_fn  = '0;
    reg_we  = 1'b1;
    mem_we  = 1'b0;
    mem_oe  = 1'b0;
    wa_sel  = 1'b0;
    case (kind)
      K_ALU: begin
        b_sel  = is_const;
        wd_sel = 2'(WDS_ALU);
        alu_fn = fn_in;
      end
      K_LD: begin
        b_sel  = 1'b1;
        wd_sel = 2'(WDS_MEM);
        alu_fn = FN_W'(FN_ADD);
        mem_oe = 1'b1;
      end
      K_ST: begin
        b_sel   = 1'b1;
        ra2_sel = 1'b1;
        alu_fn  = FN_W'(FN_ADD);
        reg_we  = 1'b0;
        mem_we  = 1'b1;
      end
      K_LDR: begin
        a_sel  = 1'b1;
        alu_fn = FN_W'(FN_PASSA);
        wd_sel = 2'(WDS_MEM);
        mem_oe = 1'b1;
      end
      K_ILL:   wa_sel = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/ctl_decode_unit.sv
module ctl_decode_unit
  import ctl_pkg::*;
#(
  parameter int OP_W = 6,
  parameter int FN_W = 4
) (
  input  logic [OP_W-1:0] op,
  input  logic            z,
  output logic [1:0]      pc_sel,
  output logic            ra2_sel,
  output logic            a_sel,
  output logic            b_sel,
  output logic [1:0]      wd_sel,
  output logic [FN_W-1:0] alu_fn,
  output logic            reg_we,
  output logic            mem_we,
  output logic            mem_oe,
  output logic            wa_sel
);
  kind_t           kind;
  logic            is_const;
  logic [FN_W-1:0] fn_raw;

  ctl_op_classify #(.OP_W(OP_W), .FN_W(FN_W)) u_cls (
    .op(op), .kind(kind), .is_const(is_const), .fn(fn_raw)
  );

  ctl_pc_steer u_pc (
    .kind(kind), .z(z), .pc_sel(pc_sel)
  );

  ctl_sel_gen #(.FN_W(FN_W)) u_sel (
    .kind(kind), .is_const(is_const), .fn_in(fn_raw),
    .ra2_sel(ra2_sel), .a_sel(a_sel), .b_sel(b_sel), .wd_sel(wd_sel),
    .alu_fn(alu_fn), .reg_we(reg_we), .mem_we(mem_we), .mem_oe(mem_oe),
    .wa_sel(wa_sel)
  );
endmodule

// File: rtl/ctl_decode_chk.sv
module ctl_decode_chk #(
  parameter int OP_W = 6,
  parameter int FN_W = 4
) (
  input logic [OP_W-1:0] op,
  input logic            z,
  input logic [1:0]      pc_sel,
  input logic            ra2_sel,
  input logic            a_sel,
  input logic            b_sel,
  input logic [1:0]      wd_sel,
  input logic [FN_W-1:0] alu_fn,
  input logic            reg_we,
  input logic            mem_we,
  input logic            mem_oe,
  input logic            wa_sel
);
  always_comb begin
    if (!$isunknown({op, z})) begin
      // R1: a taken-branch select only appears for a branch whose condition holds
      p_branch_cond_r1: assert (pc_sel != 2'd1 ||
        (op == OP_W'('h1C) && z) || (op == OP_W'('h1D) && !z));
      // R3: a trap select always saves the return address in R30
      p_trap_link_r3: assert (pc_sel != 2'd3 ||
        (reg_we && wa_sel && wd_sel == 2'd0 && !mem_we && !mem_oe));
      // R4: the Rc read path is used only by the store opcode
      p_ra2_store_r4: assert (!ra2_sel || op == OP_W'('h19));
      // R7: a memory write and a memory read are never requested together
      p_mem_excl_r7: assert (!(mem_we && mem_oe));
      // R8: a memory write never coincides with a register write
      p_st_noreg_r8: assert (!mem_we || !reg_we);
      // R6: reading memory data into a register needs the read enable
      p_wd_mem_r6: assert (wd_sel != 2'd2 || mem_oe);
      // R9: the PC-relative A path is used only with the pass-A function
      p_asel_fn_r9: assert (!a_sel || alu_fn == FN_W'(4));
    end
  end
endmodule

bind ctl_decode_unit ctl_decode_chk #(.OP_W(OP_W), .FN_W(FN_W)) u_chk (.*);

// File: tb/tb_ctl_decode_unit.sv
module tb_ctl_decode_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] op;
  logic       z;
  logic [1:0] pc_sel, wd_sel;
  logic       ra2_sel, a_sel, b_sel, reg_we, mem_we, mem_oe, wa_sel;
  logic [3:0] alu_fn;
  int         total = 0;
  int         bad   = 0;
  bit         done  = 0;

  always #2.5 clk = ~clk;

  ctl_decode_unit dut (
    .op(op), .z(z), .pc_sel(pc_sel), .ra2_sel(ra2_sel), .a_sel(a_sel),
    .b_sel(b_sel), .wd_sel(wd_sel), .alu_fn(alu_fn), .reg_we(reg_we),
    .mem_we(mem_we), .mem_oe(mem_oe), .wa_sel(wa_sel)
  );

  // Packed layout: pc(14:13) ra2(12) a(11) b(10) wd(9:8) fn(7:4) rwe(3) mwe(2) moe(1) wa(0)
  function automatic logic [14:0] model(logic [5:0] o, logic zz);
    logic [1:0] pc = 2'd0;
    logic [1:0] wd = 2'd0;
    logic [3:0] fn = 4'd0;
    logic ra2 = 0, as = 0, bs = 0, rwe = 0, mwe = 0, moe = 0, wa = 0;
    case (o)
      6'h18: begin bs = 1; wd = 2; rwe = 1; moe = 1; end
      6'h19: begin bs = 1; ra2 = 1; mwe = 1; end
      6'h1F: begin as = 1; fn = 4; wd = 2; rwe = 1; moe = 1; end
      6'h1B: begin pc = 2; rwe = 1; end
      6'h1C: begin pc = zz ? 2'd1 : 2'd0; rwe = 1; end
      6'h1D: begin pc = zz ? 2'd0 : 2'd1; rwe = 1; end
      6'h20, 6'h21, 6'h22, 6'h24, 6'h30, 6'h31, 6'h32, 6'h34: begin
        bs = o[4]; wd = 1; rwe = 1;
        fn = o[2] ? 4'd3 : {2'b00, o[1:0]};
      end
      default: begin pc = 3; rwe = 1; wa = 1; end
    endcase
    return {pc, ra2, as, bs, wd, fn, rwe, mwe, moe, wa};
  endfunction

  function automatic logic [14:0] got_vec();
    return {pc_sel, ra2_sel, a_sel, b_sel, wd_sel, alu_fn, reg_we, mem_we, mem_oe, wa_sel};
  endfunction

  task automatic chk(string tag, logic [5:0] o, logic zz, logic [14:0] g, logic [14:0] e);
    total++;
    if (g !== e) begin
      bad++;
      $display("FAIL %s op=%h z=%0b got=%h exp=%h", tag, o, zz, g, e);
    end
  endtask

  task automatic apply(logic [5:0] o, logic zz);
    @(posedge clk);
    op = o; z = zz;
    @(negedge clk);
  endtask

  task automatic check_fields(logic [5:0] o, logic zz);
    logic [14:0] g = got_vec();
    logic [14:0] e = model(o, zz);
    string pct;
    pct = (o == 6'h1C || o == 6'h1D) ? "R1" : (e[14:13] == 2'd3) ? "R3" : "R2";
    chk(pct,  o, zz, {13'd0, g[14:13]}, {13'd0, e[14:13]});
    chk("R4", o, zz, {14'd0, g[12]}, {14'd0, e[12]});
    chk("R5", o, zz, {14'd0, g[10]}, {14'd0, e[10]});
    chk("R6", o, zz, {13'd0, g[9:8]}, {13'd0, e[9:8]});
    chk("R7", o, zz, {13'd0, g[2:1]}, {13'd0, e[2:1]});
    chk("R8", o, zz, {14'd0, g[3]}, {14'd0, e[3]});
    chk("R9", o, zz, {10'd0, g[11], g[7:4]}, {10'd0, e[11], e[7:4]});
    if (e[14:13] == 2'd3) chk("R3", o, zz, {14'd0, g[0]}, {14'd0, e[0]});
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [14:0] g0;
    op = 6'h00; z = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Initial condition: opcode 0 is illegal and must trap (R3)
    check_fields(6'h00, 1'b0);
    rst = 1'b0;
    // Directed corners: branches under both flag values (R1), jump (R2)
    apply(6'h1C, 1'b1); check_fields(6'h1C, 1'b1);
    apply(6'h1C, 1'b0); check_fields(6'h1C, 1'b0);
    apply(6'h1D, 1'b1); check_fields(6'h1D, 1'b1);
    apply(6'h1D, 1'b0); check_fields(6'h1D, 1'b0);
    apply(6'h1B, 1'b0); check_fields(6'h1B, 1'b0);
    // Illegal holes next to legal codes (R3)
    apply(6'h23, 1'b0); check_fields(6'h23, 1'b0);
    apply(6'h1A, 1'b1); check_fields(6'h1A, 1'b1);
    apply(6'h3F, 1'b0); check_fields(6'h3F, 1'b0);
    // Exhaustive sweep
    for (int i = 0; i < 64; i++) begin
      for (int k = 0; k < 2; k++) begin
        apply(6'(i), k[0]); check_fields(6'(i), k[0]);
      end
    end
    // R10: flag has no effect outside the two branches
    for (int i = 0; i < 64; i++) begin
      if (i != 'h1C && i != 'h1D) begin
        apply(6'(i), 1'b0); g0 = got_vec();
        apply(6'(i), 1'b1);
        chk("R10", 6'(i), 1'b1, got_vec(), g0);
      end
    end
    // Constrained random mix, weighted toward legal opcodes
    void'($urandom(32'd4242));
    for (int n = 0; n < 400; n++) begin
      logic [5:0] ro;
      logic       rz;
      int sel = $urandom_range(0, 3);
      if (sel == 0) ro = 6'($urandom_range(0, 63));
      else          ro = 6'($urandom_range(6'h18, 6'h34));
      rz = 1'($urandom_range(0, 1));
      apply(ro, rz); check_fields(ro, rz);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule